// File: doc/BRIEF.md
# Host Controller Command/Status Register

This block is the 32-bit command and status register of a USB host controller. Software reaches it through a register port where each access is a command code plus data. A write is write-one-to-set: every data bit written as 1 sets the matching command bit, and every bit written as 0 leaves its bit as it was. Software can therefore post separate commands one after another without losing a command that is still pending.

The register holds two fields. The first is a host-controller-reset command bit at bit 0. Software sets it, and the hardware clears it when the reset sequencer reports that it has finished. The second is a read-only two-bit count of scheduling overruns at bits [17:16]. A scheduling overrun is a frame in which the periodic schedule has not completed by end-of-frame. On each overrun the count steps by one, wrapping from 3 to 0. In the same cycle the block sends a one-cycle request to the interrupt-status logic.

Top module: `hc_cmdstat_reg`

## Requirements
- R1: After reset the register reads 0, `hc_reset_req` is 0 and `sched_ovr_irq` is 0.
- R2: While `cmd_valid` is high with `cmd_code` = 02h, `rd_data` shows the register in the same cycle: bit 0 is the reset command bit, bits [17:16] are the overrun count, and every other bit is 0. At any other time `rd_data` is 0.
- R3: A write (`cmd_valid` high, `cmd_code` = 82h) with data bit 0 = 1 sets the reset command bit from the next cycle. A write with bit 0 = 0 leaves the bit unchanged, so writing 0 cannot clear it.
- R4: When `reset_done` is high, the reset command bit reads 0 from the next cycle. A write setting bit 0 in the same cycle as `reset_done` takes priority, and the bit stays 1.
- R5: Written data in bits other than bit 0 has no effect. This includes the count bits [17:16] and every reserved bit.
- R6: Each cycle with `sched_overrun` high adds 1 to the overrun count from the next cycle, and the count wraps from 3 to 0.
- R7: `sched_ovr_irq` is high for exactly the one cycle in which the incremented count first appears, and for no other cycle.
- R8: A command with a code other than 02h or 82h changes nothing. Data with bit 0 = 1 sent under such a code does not set the reset command bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Register access strobe |
| cmd_code | input | 8 | Access command code (02h read, 82h write) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while a read command is presented |
| sched_overrun | input | 1 | One-cycle event: the periodic schedule missed end-of-frame |
| reset_done | input | 1 | Reset sequencer has finished |
| hc_reset_req | output | 1 | Current value of the reset command bit |
| sched_ovr_irq | output | 1 | One-cycle interrupt request on a scheduling overrun |

## Verification
Several properties are checked on every cycle. Reserved read bits must stay 0. A set reset command bit may drop only after `reset_done`. A write of bit 0 must take effect. Each overrun must step the count by exactly one, and any change of the count must come with the interrupt pulse. Other behaviour shows only in the bench's scenarios: the values actually read back under 02h, writes that leave pending commands intact, the set-over-clear priority, the wrap from 3 to 0, and the absence of effect from foreign codes and from writes to the count field.

// File: rtl/hc_cmdstat_reg.sv
module hc_cmdstat_reg #(
  parameter int DATA_W  = 32,
  parameter int CODE_W  = 8,
  parameter logic [CODE_W-1:0] RD_CODE = 'h02,
  parameter logic [CODE_W-1:0] WR_CODE = 'h82,
  parameter int HCR_BIT = 0,
  parameter int CNT_LSB = 16,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sched_overrun,
  input  logic              reset_done,
  output logic              hc_reset_req,
  output logic              sched_ovr_irq
);

  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'(1) << HCR_BIT) | (DATA_W'((1 << CNT_W) - 1) << CNT_LSB);

  logic [CNT_W-1:0] ovr_cnt;
  logic             hcr_q;

  wire rd_hit = cmd_valid && (cmd_code == RD_CODE);
  wire wr_hit = cmd_valid && (cmd_code == WR_CODE);
  wire hcr_set = wr_hit && wr_data[HCR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hcr_q <= 1'b0;
    else if (hcr_set)     hcr_q <= 1'b1;
    else if (reset_done)  hcr_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_cnt       <= '0;
      sched_ovr_irq <= 1'b0;
    end else begin
      sched_ovr_irq <= sched_overrun;
      if (sched_overrun) ovr_cnt <= ovr_cnt + 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      rd_data[HCR_BIT]               = hcr_q;
      rd_data[CNT_LSB +: CNT_W]      = ovr_cnt;
    end
  end

  assign hc_reset_req = hcr_q;

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == '0);

  p_idle_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == '0);

  p_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hcr_set |=> hc_reset_req);

  p_hcr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_reset_req && !reset_done) |=> hc_reset_req);

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sched_overrun |=> ovr_cnt == CNT_W'($past(ovr_cnt) + 1'b1));

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_overrun |=> $stable(ovr_cnt));

  p_irq_with_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_cnt != $past(ovr_cnt)) |-> sched_ovr_irq);

endmodule

// File: tb/hc_cmdstat_reg_tb.sv
module hc_cmdstat_reg_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [7:0]  cmd_code = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        sched_overrun = 0;
  logic        reset_done = 0;
  logic        hc_reset_req;
  logic        sched_ovr_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic       m_hcr = 0;
  logic [1:0] m_cnt = 0;

  always #5 clk = ~clk;

  hc_cmdstat_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_data(wr_data), .rd_data(rd_data), .sched_overrun(sched_overrun),
    .reset_done(reset_done), .hc_reset_req(hc_reset_req),
    .sched_ovr_irq(sched_ovr_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_val();
    return {14'd0, m_cnt, 15'd0, m_hcr};
  endfunction

  always @(negedge clk) begin
    if (cmd_valid && cmd_code == 8'h02) begin
      if (exp_q.size() == 0) check("R2 unexpected read", rd_data, 32'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic do_read(string req);
    @(posedge clk); #1;
    exp_q.push_back(model_val());
    tag_q.push_back(req);
    cmd_valid = 1; cmd_code = 8'h02;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_code = 8'h00;
  endtask

  task automatic do_cmd(logic [7:0] code, logic [31:0] data, logic done);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_code = code; wr_data = data; reset_done = done;
    if (code == 8'h82 && data[0]) m_hcr = 1;
    else if (done) m_hcr = 0;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_code = 0; wr_data = 0; reset_done = 0;
  endtask

  task automatic do_overrun(string req);
    @(posedge clk); #1;
    sched_overrun = 1;
    m_cnt = m_cnt + 1;
    @(posedge clk); #1;
    sched_overrun = 0;
    check({req, " irq high"}, {31'd0, sched_ovr_irq}, 32'd1);
    @(posedge clk); #1;
    check({req, " irq gone"}, {31'd0, sched_ovr_irq}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 hcr", {31'd0, hc_reset_req}, 32'd0);
    check("R1 irq", {31'd0, sched_ovr_irq}, 32'd0);
    check("R2 idle read zero", rd_data, 32'd0);
    do_read("R1 reset value");

    do_cmd(8'h82, 32'h0000_0001, 0);
    check("R3 hcr set", {31'd0, hc_reset_req}, 32'd1);
    do_read("R3 read after set");
    do_cmd(8'h82, 32'h0000_0000, 0);
    do_read("R3 zero write keeps bit");

    do_cmd(8'h00, 32'h0000_0000, 1);
    check("R4 cleared by done", {31'd0, hc_reset_req}, 32'd0);
    do_cmd(8'h82, 32'h0000_0001, 1);
    check("R4 set wins over done", {31'd0, hc_reset_req}, 32'd1);
    do_read("R4 read after tie");
    do_cmd(8'h00, 32'h0, 1);

    do_cmd(8'h82, 32'hFFFF_FFFE, 0);
    do_read("R5 other bits ignored");
    check("R5 hcr untouched", {31'd0, hc_reset_req}, 32'd0);

    do_cmd(8'h81, 32'hFFFF_FFFF, 0);
    do_cmd(8'h02 ^ 8'h80 ^ 8'h01, 32'h1, 0);
    do_read("R8 foreign codes ignored");
    check("R8 hcr stays clear", {31'd0, hc_reset_req}, 32'd0);

    for (int i = 0; i < 5; i++) begin
      do_overrun("R7");
      do_read("R6 count step");
    end

    do_cmd(8'h82, 32'h0003_0000, 0);
    do_read("R5 count not writable");

    do_cmd(8'h82, 32'h1, 0);
    do_overrun("R7 with hcr set");
    do_read("R6 hcr and count together");

    repeat (2) @(posedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule